// File: doc/BRIEF.md
# Adaptive-Rate Digital Regulator Controller

This block is the digital control loop of a low-dropout regulator built from a bank of parallel power switches. It runs from its own sampling clock. On each sample it reads a single comparator decision: is the regulated output below the reference, or above it? It then adds or removes one conducting switch. The switch enables form a thermometer code, so the number of conducting devices is always a contiguous run starting at bit 0.

Sampling normally runs at a slow, stable rate, which is a fraction of the block clock. When an external droop detector signals a large droop, the controller moves to a fast rate and samples on every clock, so that it recovers sooner. Once the droop detector has stayed quiet for a run of consecutive fast samples, the controller returns to the slow rate.

Regulation runs only while software has enabled the loop and the target is flagged as lying inside the regulator's usable window. At all other times every switch is off.

Top module: `ldo_adaptive_ctrl`

## Requirements
- R1: In slow mode the switch count changes at most once per SLOW_DIV (default 8) clocks. After regulation starts, or after a return to slow mode, the first step falls on the SLOW_DIV-th clock edge.
- R2: On each sample the count rises by one when `cmpBelow` is 1 (output below reference), and falls by one when `cmpBelow` is 0 (output above reference).
- R3: The count saturates at 0 and at NUM_SW (default 32) and never wraps. When a sample's step is blocked by a limit, `satFlag` goes to 1. The next sample that does move the count clears it.
- R4: `swEn[i]` is 1 exactly when i < `activeCount`, so the enables form a thermometer code.
- R5: While regulating, a 1 on `droopDet` puts the block in fast mode (`fastMode` = 1) from the next clock. In fast mode a sample is taken on every clock.
- R6: Fast mode ends after SETTLE_RUN (default 16) consecutive fast samples with `droopDet` at 0. Any sample with `droopDet` at 1 restarts that run.
- R7: When `swEnable` or `windowOk` is 0, the next clock forces the count to 0, slow mode and `satFlag` to 0. While either is 0, `droopDet` and `cmpBelow` have no effect.
- R8: An active-low `rstN` clears the count, the mode and `satFlag` at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Regulator sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swEnable | input | 1 | Software enable for regulation |
| windowOk | input | 1 | Target voltage lies in the usable window |
| cmpBelow | input | 1 | Comparator: 1 = output below reference, 0 = above |
| droopDet | input | 1 | Large-droop detector |
| swEn | output | NUM_SW | Thermometer-coded power switch enables |
| activeCount | output | $clog2(NUM_SW+1) | Number of conducting switches |
| fastMode | output | 1 | 1 = fast sampling, 0 = slow sampling |
| satFlag | output | 1 | Last sample was blocked at a limit |

## Verification
The bench first counts the idle clocks before the first slow step. A divider with the wrong phase or terminal value would move the count one clock early or late. It then drives the count into both limits and holds the step direction there. A wrapping counter would jump to the far end, and a wrong flag would stay clear while blocked or stay set after the count moves. The fast-to-slow exit is checked one sample before and one sample at the settle limit, with a droop pulse placed mid-run. An off-by-one run counter, or one that never restarts, would leave fast mode at the wrong clock. Finally, the enable and window inputs are dropped while in fast mode and at full count, and droop is then asserted while disabled. This exposes a design that keeps switches on or enters fast mode when it should be idle.

// File: rtl/ldo_ctrl_pkg.sv
package ldo_ctrl_pkg;

  typedef enum logic {
    MODE_SLOW = 1'b0,
    MODE_FAST = 1'b1
  } sampleMode_t;

  // Strobes from the sequencing control to the switch-count datapath
  typedef struct packed {
    logic clear;  // force count to zero and drop the flag
    logic step;   // take one sample this clock
    logic up;     // direction of the step: 1 = add a switch
  } ldoStrobe_t;

endpackage

// File: rtl/ldo_sample_ctrl.sv
module ldo_sample_ctrl
  import ldo_ctrl_pkg::*;
#(
  parameter int SLOW_DIV   = 8,
  parameter int SETTLE_RUN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regActive,
  input  logic       cmpBelow,
  input  logic       droopDet,
  output ldoStrobe_t strobe,
  output logic       fastMode
);

  localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int QW = $clog2(SETTLE_RUN + 1);
  localparam logic [DW-1:0] DIV_LAST    = DW'(SLOW_DIV - 1);
  localparam logic [QW-1:0] SETTLE_LAST = QW'(SETTLE_RUN - 1);

  sampleMode_t modeQ;
  logic [DW-1:0] divCnt;
  logic [QW-1:0] quietCnt;
  logic          tick;

  // A sample is due every clock in fast mode, or on the divider's last phase
  always_comb begin
    tick         = regActive && ((modeQ == MODE_FAST) || (divCnt == DIV_LAST));
    strobe.clear = !regActive;
    strobe.step  = tick;
    strobe.up    = cmpBelow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_SLOW;
      divCnt   <= '0;
      quietCnt <= '0;
    end else if (!regActive) begin
      modeQ    <= MODE_SLOW;
      divCnt   <= '0;
      quietCnt <= '0;
    end else begin
      unique case (modeQ)
        MODE_SLOW: begin
          if (droopDet) begin
            modeQ    <= MODE_FAST;
            divCnt   <= '0;
            quietCnt <= '0;
          end else if (divCnt == DIV_LAST) begin
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + DW'(1);
          end
        end
        MODE_FAST: begin
          if (droopDet) begin
            quietCnt <= '0;
          end else if (quietCnt == SETTLE_LAST) begin
            modeQ    <= MODE_SLOW;
            quietCnt <= '0;
            divCnt   <= '0;
          end else begin
            quietCnt <= quietCnt + QW'(1);
          end
        end
        default: modeQ <= MODE_SLOW;
      endcase
    end
  end

  assign fastMode = (modeQ == MODE_FAST);

  // R5
  droop_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regActive && droopDet) |=> fastMode);

  // R6
  stay_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regActive && fastMode && droopDet) |=> fastMode);

  // R6
  quiet_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietCnt <= SETTLE_LAST);

  // R7
  idle_slow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regActive |=> !fastMode);

  // R1
  slow_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regActive && !fastMode && strobe.step && !droopDet) |=> !strobe.step);

endmodule

// File: rtl/ldo_switch_path.sv
module ldo_switch_path
  import ldo_ctrl_pkg::*;
#(
  parameter int NUM_SW = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ldoStrobe_t                  strobe,
  output logic [NUM_SW-1:0]           swEn,
  output logic [$clog2(NUM_SW+1)-1:0] activeCount,
  output logic                        satFlag
);

  localparam int CW = $clog2(NUM_SW + 1);
  localparam logic [CW-1:0] FULL = CW'(NUM_SW);

  logic [CW-1:0] countQ;
  logic          satQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      satQ   <= 1'b0;
    end else if (strobe.clear) begin
      countQ <= '0;
      satQ   <= 1'b0;
    end else if (strobe.step) begin
      if (strobe.up) begin
        if (countQ == FULL) begin
          satQ <= 1'b1;
        end else begin
          countQ <= countQ + CW'(1);
          satQ   <= 1'b0;
        end
      end else begin
        if (countQ == '0) begin
          satQ <= 1'b1;
        end else begin
          countQ <= countQ - CW'(1);
          satQ   <= 1'b0;
        end
      end
    end
  end

  // Thermometer decode: one comparator per switch
  for (genvar i = 0; i < NUM_SW; i++) begin : gThermo
    assign swEn[i] = (countQ > CW'(i));
  end

  assign activeCount = countQ;
  assign satFlag     = satQ;

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL);

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> (countQ == $past(countQ)) ||
                      (countQ == $past(countQ) + CW'(1)) ||
                      (countQ == $past(countQ) - CW'(1)));

  // R4
  thermo_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((swEn & (swEn + NUM_SW'(1))) == '0) && ($countones(swEn) == int'(countQ)));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (countQ == '0) && !satQ);

  // R3
  hold_no_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.step) |=> $stable(countQ) && $stable(satQ));

endmodule

// File: rtl/ldo_adaptive_ctrl.sv
module ldo_adaptive_ctrl
  import ldo_ctrl_pkg::*;
#(
  parameter int NUM_SW     = 32,
  parameter int SLOW_DIV   = 8,
  parameter int SETTLE_RUN = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        swEnable,
  input  logic                        windowOk,
  input  logic                        cmpBelow,
  input  logic                        droopDet,
  output logic [NUM_SW-1:0]           swEn,
  output logic [$clog2(NUM_SW+1)-1:0] activeCount,
  output logic                        fastMode,
  output logic                        satFlag
);

  ldoStrobe_t strobe;
  logic       regActive;

  assign regActive = swEnable && windowOk;

  ldo_sample_ctrl #(
    .SLOW_DIV  (SLOW_DIV),
    .SETTLE_RUN(SETTLE_RUN)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regActive(regActive),
    .cmpBelow (cmpBelow),
    .droopDet (droopDet),
    .strobe   (strobe),
    .fastMode (fastMode)
  );

  ldo_switch_path #(
    .NUM_SW(NUM_SW)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .swEn       (swEn),
    .activeCount(activeCount),
    .satFlag    (satFlag)
  );

  // R7
  off_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regActive |=> (swEn == '0) && !fastMode);

endmodule

// File: tb/ldo_adaptive_ctrl_test.sv
module ldo_adaptive_ctrl_test;

  localparam int NUM_SW = 32;
  localparam int CW     = $clog2(NUM_SW + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swEnable = 1'b0, windowOk = 1'b0, cmpBelow = 1'b0, droopDet = 1'b0;
  logic [NUM_SW-1:0] swEn;
  logic [CW-1:0]     activeCount;
  logic              fastMode, satFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ldo_adaptive_ctrl #(.NUM_SW(NUM_SW), .SLOW_DIV(8), .SETTLE_RUN(16)) uut (
    .clk(clk), .rstN(rstN), .swEnable(swEnable), .windowOk(windowOk),
    .cmpBelow(cmpBelow), .droopDet(droopDet), .swEn(swEn),
    .activeCount(activeCount), .fastMode(fastMode), .satFlag(satFlag)
  );

  typedef struct packed {
    logic       en;
    logic       win;
    logic       below;
    logic       droop;
    logic [7:0] cycles;
    logic [7:0] expCount;
    logic       expFast;
    logic       expSat;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,1'b1,1'b1,1'b0, 8'd16, 8'd2,  1'b0,1'b0, 4'd1}, // R1 R2 two slow steps
    '{1'b1,1'b1,1'b1,1'b1, 8'd1,  8'd2,  1'b1,1'b0, 4'd5}, // R5 entry, no step
    '{1'b1,1'b1,1'b1,1'b0, 8'd10, 8'd12, 1'b1,1'b0, 4'd5}, // R5 step per clock
    '{1'b1,1'b1,1'b1,1'b0, 8'd5,  8'd17, 1'b1,1'b0, 4'd6}, // R6 15 quiet: still fast
    '{1'b1,1'b1,1'b1,1'b0, 8'd1,  8'd18, 1'b0,1'b0, 4'd6}, // R6 16th quiet: slow
    '{1'b1,1'b1,1'b0,1'b0, 8'd7,  8'd18, 1'b0,1'b0, 4'd1}, // R1 no step yet
    '{1'b1,1'b1,1'b0,1'b0, 8'd1,  8'd17, 1'b0,1'b0, 4'd2}, // R2 R1 step down on 8th
    '{1'b1,1'b1,1'b0,1'b1, 8'd1,  8'd17, 1'b1,1'b0, 4'd5}, // R5
    '{1'b1,1'b1,1'b0,1'b1, 8'd17, 8'd0,  1'b1,1'b0, 4'd2}, // R2 down to zero
    '{1'b1,1'b1,1'b0,1'b1, 8'd1,  8'd0,  1'b1,1'b1, 4'd3}, // R3 blocked at zero
    '{1'b1,1'b1,1'b1,1'b1, 8'd1,  8'd1,  1'b1,1'b0, 4'd3}, // R3 flag clears
    '{1'b1,1'b1,1'b1,1'b1, 8'd40, 8'd32, 1'b1,1'b1, 4'd3}, // R3 top, no wrap
    '{1'b1,1'b1,1'b1,1'b0, 8'd15, 8'd32, 1'b1,1'b1, 4'd6}, // R6
    '{1'b1,1'b1,1'b1,1'b1, 8'd1,  8'd32, 1'b1,1'b1, 4'd6}, // R6 run restart
    '{1'b1,1'b1,1'b1,1'b0, 8'd15, 8'd32, 1'b1,1'b1, 4'd6}, // R6 still fast
    '{1'b1,1'b1,1'b1,1'b0, 8'd1,  8'd32, 1'b0,1'b1, 4'd6}, // R6 exit
    '{1'b1,1'b0,1'b1,1'b0, 8'd1,  8'd0,  1'b0,1'b0, 4'd7}, // R7 window drop
    '{1'b1,1'b0,1'b1,1'b1, 8'd10, 8'd0,  1'b0,1'b0, 4'd7}, // R7 droop ignored
    '{1'b0,1'b1,1'b1,1'b1, 8'd5,  8'd0,  1'b0,1'b0, 4'd7}, // R7 enable low
    '{1'b1,1'b1,1'b1,1'b1, 8'd1,  8'd0,  1'b1,1'b0, 4'd5}, // R5
    '{1'b1,1'b1,1'b1,1'b1, 8'd5,  8'd5,  1'b1,1'b0, 4'd5}, // R5
    '{1'b0,1'b1,1'b1,1'b1, 8'd1,  8'd0,  1'b0,1'b0, 4'd7}  // R7 drop in fast mode
  };

  function automatic logic [NUM_SW-1:0] thermo(input int n);
    logic [NUM_SW:0] t;
    t = (NUM_SW+1)'(1) << n;
    return NUM_SW'(t - (NUM_SW+1)'(1));
  endfunction

  task automatic checkState(input int req, input string tag, input int eCount,
                            input logic eFast, input logic eSat);
    checks++;
    if (int'(activeCount) != eCount || fastMode !== eFast || satFlag !== eSat) begin
      errors++;
      $display("FAIL R%0d %s: count=%0d fast=%0b sat=%0b expected count=%0d fast=%0b sat=%0b",
               req, tag, activeCount, fastMode, satFlag, eCount, eFast, eSat);
    end
    checks++;
    if (swEn !== thermo(eCount)) begin  // R4 thermometer shape
      errors++;
      $display("FAIL R4 %s: swEn=%h expected %h", tag, swEn, thermo(eCount));
    end
  endtask

  initial begin
    #1;
    checkState(8, "reset state", 0, 1'b0, 1'b0);  // R8
    @(negedge clk);
    rstN = 1'b1;
    for (int v = 0; v < NV; v++) begin
      swEnable = VEC[v].en;
      windowOk = VEC[v].win;
      cmpBelow = VEC[v].below;
      droopDet = VEC[v].droop;
      repeat (int'(VEC[v].cycles)) @(posedge clk);
      @(negedge clk);
      checkState(int'(VEC[v].req), $sformatf("vector %0d", v),
                 int'(VEC[v].expCount), VEC[v].expFast, VEC[v].expSat);
    end
    // R8: asynchronous reset mid-operation
    swEnable = 1'b1; windowOk = 1'b1; cmpBelow = 1'b1; droopDet = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    checkState(5, "pre-reset climb", 7, 1'b1, 1'b0);  // R5 entry + 7 steps
    #1 rstN = 1'b0;
    #0.5;
    checkState(8, "async reset", 0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    droopDet = 1'b0;
    // R1: first slow step falls on the 8th edge after reset release
    repeat (7) @(posedge clk);
    @(negedge clk);
    checkState(1, "slow phase 7", 0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    checkState(1, "slow phase 8", 1, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule